// File: doc/BRIEF.md
# Reloadable Overflow-Pulse Watchdog Timer

This block is one channel of a 24-bit up-counting timer used as a watchdog. Software writes a starting value, a match value and a control word through three simple write strobes. Once the channel is enabled in its pulse mode, the first timer tick copies the starting value into the counter. Every later tick adds one. The timer tick is a single-cycle enable input. It may come from a divide-by-two of the system clock or from a prescaler.

When a tick brings the count to the match value, a sticky match flag is set. If reload mode is on, the tick after that match restarts the count from the starting value. When the count passes all ones, it wraps to zero and a sticky overflow flag is set. The output pin then carries an active pulse for exactly one tick interval, and its active level is chosen by an invert control. Each interrupt output is a level: its flag ANDed with its enable. Each flag is cleared by a write-one clear strobe.

Top module: `wdog_pulse_timer`

## Requirements
- R1: The counter runs only while the enable control is 1 and the 4-bit mode field equals 4'b1001. In any other state the count is held at zero, no flag is set and the pin stays inactive.
- R2: After a synchronous reset, all of the following are zero: the count, both flags, both interrupts, the pin and every configuration field.
- R3: On the first tick after the channel becomes active, the count takes the starting value.
- R4: Each later tick increments the count by one. A cycle without a tick leaves the count unchanged.
- R5: A tick that leaves the count equal to the match value sets the match flag, and the flag stays set until it is cleared.
- R6: With reload mode on, the tick that follows a match loads the starting value instead of incrementing. With reload mode off, counting continues past the match value.
- R7: A tick taken at count 24'hFFFFFF wraps the count to 0 and sets the overflow flag, which stays set until it is cleared.
- R8: The pin equals the invert control XOR an internal pulse. The pulse becomes 1 at the overflow tick and returns to 0 at the next tick. The pulse is therefore active for one full tick interval.
- R9: The match interrupt is the match flag AND the match-interrupt enable. The overflow interrupt is the overflow flag AND the overflow-interrupt enable.
- R10: A 1 on a clear strobe clears its flag in the next cycle. An event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick enable, one cycle per tick |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_mode | input | 4 | Mode field, 4'b1001 selects pulse mode |
| cfg_enable | input | 1 | Channel enable |
| cfg_reload | input | 1 | Reload on match |
| cfg_invert | input | 1 | Pin polarity, 1 makes the pulse low |
| cfg_cmp_ie | input | 1 | Match interrupt enable |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| load_we | input | 1 | Write strobe for the starting value |
| load_data | input | CNT_W | Starting value |
| cmp_we | input | 1 | Write strobe for the match value |
| cmp_data | input | CNT_W | Match value |
| clr_cmp | input | 1 | Write-one clear of the match flag |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| count | output | CNT_W | Current count |
| cmp_flag | output | 1 | Sticky match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Match interrupt level |
| ovf_irq | output | 1 | Overflow interrupt level |
| pulse_pin | output | 1 | Overflow pulse pin |

## Verification
The properties assume that the match value is not rewritten while the channel counts. They also assume that the invert control changes only while the channel is inactive, because a pin or match check would otherwise compare against a value that changed at the same edge. The stimulus follows both rules: starting and match values and polarity are written only with the channel disabled, and a disabling write repeats the current polarity. Ticks are applied with idle gaps of several lengths, so that the hold and pulse-width properties are exercised between ticks.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_PULSE = 4'b1001;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              enable;
    logic              reload;
    logic              invert;
    logic              cmp_ie;
    logic              ovf_ie;
  } wdp_cfg_t;
endpackage

// File: rtl/wdp_cfg_regs.sv
module wdp_cfg_regs
  import wdp_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  wdp_cfg_t         cfg_in,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_data,
  output wdp_cfg_t         cfg_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      load_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_in;
      if (load_we) load_q <= load_data;
      if (cmp_we)  cmp_q  <= cmp_data;
    end
  end

  // channel runs only in pulse mode with enable set
  assign active = cfg_q.enable && (cfg_q.mode == MODE_PULSE);
endmodule

// File: rtl/wdp_counter.sv
module wdp_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             active,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] cmp_q,
  output logic [CNT_W-1:0] count,
  output logic             cmp_ev,
  output logic             ovf_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             armed_nxt;
  logic             at_match;

  assign at_match = (count == cmp_q);

  always_comb begin
    cnt_nxt   = count;
    armed_nxt = armed_q;
    ovf_ev    = 1'b0;
    cmp_ev    = 1'b0;
    if (!active) begin
      cnt_nxt   = '0;
      armed_nxt = 1'b0;
    end else if (tick) begin
      if (!armed_q) begin
        cnt_nxt   = load_q;
        armed_nxt = 1'b1;
      end else if (reload && at_match) begin
        cnt_nxt = load_q;
      end else begin
        cnt_nxt = count + 1'b1;
        ovf_ev  = (count == CNT_MAX);
      end
      cmp_ev = (cnt_nxt == cmp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      armed_q <= 1'b0;
    end else begin
      count   <= cnt_nxt;
      armed_q <= armed_nxt;
    end
  end
endmodule

// File: rtl/wdp_status.sv
module wdp_status (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic cmp_ev,
  input  logic ovf_ev,
  input  logic clr_cmp,
  input  logic clr_ovf,
  input  logic cmp_ie,
  input  logic ovf_ie,
  input  logic invert,
  output logic cmp_flag,
  output logic ovf_flag,
  output logic cmp_irq,
  output logic ovf_irq,
  output logic pulse_pin
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      // an event in the same cycle wins over a clear
      cmp_flag <= (cmp_flag && !clr_cmp) || cmp_ev;
      ovf_flag <= (ovf_flag && !clr_ovf) || ovf_ev;
      if (!active)   pulse_q <= 1'b0;
      else if (tick) pulse_q <= ovf_ev;
    end
  end

  assign cmp_irq   = cmp_flag && cmp_ie;
  assign ovf_irq   = ovf_flag && ovf_ie;
  assign pulse_pin = pulse_q ^ invert;
endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer
  import wdp_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_mode,
  input  logic             cfg_enable,
  input  logic             cfg_reload,
  input  logic             cfg_invert,
  input  logic             cfg_cmp_ie,
  input  logic             cfg_ovf_ie,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_data,
  input  logic             clr_cmp,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic             cmp_irq,
  output logic             ovf_irq,
  output logic             pulse_pin
);
  wdp_cfg_t         cfg_in;
  wdp_cfg_t         cfg_q;
  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cmp_q;
  logic             active;
  logic             cmp_ev;
  logic             ovf_ev;
  logic             inv_q;

  always_comb begin
    cfg_in.mode   = cfg_mode;
    cfg_in.enable = cfg_enable;
    cfg_in.reload = cfg_reload;
    cfg_in.invert = cfg_invert;
    cfg_in.cmp_ie = cfg_cmp_ie;
    cfg_in.ovf_ie = cfg_ovf_ie;
  end

  assign inv_q = cfg_q.invert;

  wdp_cfg_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_in(cfg_in),
    .load_we(load_we), .load_data(load_data),
    .cmp_we(cmp_we), .cmp_data(cmp_data),
    .cfg_q(cfg_q), .load_q(load_q), .cmp_q(cmp_q), .active(active)
  );

  wdp_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .reload(cfg_q.reload), .load_q(load_q), .cmp_q(cmp_q),
    .count(count), .cmp_ev(cmp_ev), .ovf_ev(ovf_ev)
  );

  wdp_status stat_i (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .cmp_ev(cmp_ev), .ovf_ev(ovf_ev),
    .clr_cmp(clr_cmp), .clr_ovf(clr_ovf),
    .cmp_ie(cfg_q.cmp_ie), .ovf_ie(cfg_q.ovf_ie), .invert(inv_q),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pulse_pin(pulse_pin)
  );
endmodule

// File: rtl/wdp_checker.sv
module wdp_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_q,
  input logic             cmp_ev,
  input logic             clr_cmp,
  input logic             cmp_flag,
  input logic             ovf_flag,
  input logic             cmp_irq,
  input logic             ovf_irq,
  input logic             pulse_pin
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !active |=> (count == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> (count == $past(count)));

  p_match_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> (count == cmp_q));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (count == '0 && $past(count) == {CNT_W{1'b1}}));

  p_pin_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(pulse_pin));

  p_cmp_irq_r9: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> cmp_flag);

  p_ovf_irq_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> ovf_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_cmp && !cmp_ev) |=> !cmp_flag);
endmodule

bind wdog_pulse_timer wdp_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .active(active), .count(count),
  .cmp_q(cmp_q), .cmp_ev(cmp_ev), .clr_cmp(clr_cmp),
  .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
  .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pulse_pin(pulse_pin)
);

// File: tb/wdog_pulse_timer_tb_top.sv
module wdog_pulse_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic cf, of, ci, oi, pin;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, cfg_we = 0, cfg_enable = 0, cfg_reload = 0, cfg_invert = 0;
  logic cfg_cmp_ie = 0, cfg_ovf_ie = 0, load_we = 0, cmp_we = 0;
  logic clr_cmp = 0, clr_ovf = 0;
  logic [3:0] cfg_mode = '0;
  logic [CNT_W-1:0] load_data = '0, cmp_data = '0;
  logic [CNT_W-1:0] count;
  logic cmp_flag, ovf_flag, cmp_irq, ovf_irq, pulse_pin;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R2";
  exp_t q[$];

  // reference model state
  logic [3:0] m_mode = '0;
  logic m_en = 0, m_rel = 0, m_inv = 0, m_cie = 0, m_oie = 0;
  logic [CNT_W-1:0] m_load = '0, m_cmp = '0, m_cnt = '0;
  logic m_arm = 0, m_pulse = 0, m_cf = 0, m_of = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_pulse_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_enable(cfg_enable), .cfg_reload(cfg_reload), .cfg_invert(cfg_invert),
    .cfg_cmp_ie(cfg_cmp_ie), .cfg_ovf_ie(cfg_ovf_ie),
    .load_we(load_we), .load_data(load_data), .cmp_we(cmp_we), .cmp_data(cmp_data),
    .clr_cmp(clr_cmp), .clr_ovf(clr_ovf), .count(count), .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag), .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pulse_pin(pulse_pin)
  );

  task automatic check(string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  // model one clock edge from the inputs now on the pins, push expectation
  task automatic model_step();
    exp_t e;
    logic ce, oe;
    ce = 0; oe = 0;
    if (!(m_en && m_mode == 4'b1001)) begin
      m_cnt = '0; m_arm = 0; m_pulse = 0;
    end else if (tick) begin
      if (!m_arm) begin m_cnt = m_load; m_arm = 1; end
      else if (m_rel && m_cnt == m_cmp) m_cnt = m_load;
      else begin oe = (m_cnt == {CNT_W{1'b1}}); m_cnt = m_cnt + 1'b1; end
      ce = (m_cnt == m_cmp);
      m_pulse = oe;
    end
    m_cf = (m_cf & ~clr_cmp) | ce;
    m_of = (m_of & ~clr_ovf) | oe;
    if (cfg_we) begin
      m_mode = cfg_mode; m_en = cfg_enable; m_rel = cfg_reload;
      m_inv = cfg_invert; m_cie = cfg_cmp_ie; m_oie = cfg_ovf_ie;
    end
    if (load_we) m_load = load_data;
    if (cmp_we) m_cmp = cmp_data;
    e.cnt = m_cnt; e.cf = m_cf; e.of = m_of;
    e.ci = m_cf & m_cie; e.oi = m_of & m_oie; e.pin = m_pulse ^ m_inv;
    e.req = cur_req;
    q.push_back(e);
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    tick = 0; cfg_we = 0; load_we = 0; cmp_we = 0; clr_cmp = 0; clr_ovf = 0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; cycle();
      for (int j = 0; j < gap; j++) cycle();
    end
  endtask

  task automatic set_cfg(logic [3:0] md, logic en, logic rel, logic inv, logic cie, logic oie);
    cfg_mode = md; cfg_enable = en; cfg_reload = rel; cfg_invert = inv;
    cfg_cmp_ie = cie; cfg_ovf_ie = oie; cfg_we = 1; cycle();
  endtask

  task automatic set_vals(logic [CNT_W-1:0] ld, logic [CNT_W-1:0] cp);
    load_data = ld; load_we = 1; cmp_data = cp; cmp_we = 1; cycle();
  endtask

  // monitor: compare after each edge against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        string sv;
        e = q.pop_front();
        sv = cur_req;
        cur_req = e.req;
        check("count(R4)", count, e.cnt);
        check("cmp_flag(R5)", {23'd0, cmp_flag}, {23'd0, e.cf});
        check("ovf_flag(R7)", {23'd0, ovf_flag}, {23'd0, e.of});
        check("cmp_irq(R9)", {23'd0, cmp_irq}, {23'd0, e.ci});
        check("ovf_irq(R9)", {23'd0, ovf_irq}, {23'd0, e.oi});
        check("pin(R8)", {23'd0, pulse_pin}, {23'd0, e.pin});
        cur_req = sv;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R2";
    check("reset count", count, '0);
    check("reset flags", {22'd0, cmp_flag, ovf_flag}, '0);
    check("reset irqs", {22'd0, cmp_irq, ovf_irq}, '0);
    check("reset pin", {23'd0, pulse_pin}, '0);

    cur_req = "R1";
    set_vals(24'd5, 24'd7);
    set_cfg(4'b0001, 1, 0, 0, 1, 1);
    ticks(3, 1);
    set_cfg(4'b1001, 0, 0, 0, 1, 1);
    ticks(2, 0);

    cur_req = "R3";
    set_cfg(4'b1001, 1, 0, 0, 1, 0);
    ticks(1, 3);
    cur_req = "R4";
    ticks(1, 2);
    cur_req = "R5";
    ticks(1, 1);
    ticks(3, 0);
    cur_req = "R10";
    clr_cmp = 1; cycle();
    cycle();

    cur_req = "R6";
    set_cfg(4'b1001, 0, 1, 0, 1, 0);
    set_vals(24'd10, 24'd12);
    set_cfg(4'b1001, 1, 1, 0, 1, 0);
    ticks(7, 1);
    cur_req = "R10";
    ticks(1, 0);
    ticks(1, 0);
    tick = 1; clr_cmp = 1; cycle();
    cycle();

    cur_req = "R7";
    set_cfg(4'b1001, 0, 0, 0, 0, 1);
    set_vals(24'hFFFFFD, 24'h000003);
    set_cfg(4'b1001, 1, 0, 1, 0, 1);
    ticks(3, 2);
    cur_req = "R8";
    ticks(1, 4);
    ticks(2, 1);
    cur_req = "R9";
    clr_ovf = 1; cycle();
    cycle();
    cur_req = "R1";
    set_cfg(4'b1001, 0, 0, 1, 0, 1);
    ticks(2, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule